// File: doc/BRIEF.md
# Port-Input Block Transfer Sequencer

This block moves bytes from an I/O port into memory under the control of three register pairs that it keeps itself: a 16-bit count/port pair BC, a pointer pair DE and a memory pointer HL. For each byte it runs one I/O read cycle, then one memory write cycle that stores the same byte at HL. It then decrements the registers the selected variant names and updates two condition flags. Z reports that the counter has run out. N copies the top bit of the byte just moved.

A two-bit mode input, sampled on `start_i`, selects one of three variants:

- Mode 0 (single step) takes the port address from BC and decrements B and HL.
- Mode 1 (single step, both counters) does the same and also decrements C.
- Mode 2 (repeat) takes the port address from DE. It decrements BC, DE and HL on every pass and loops until BC has run out.

The bus is a plain request/acknowledge handshake, so real devices may insert wait states. The registers are loaded through a side port while the block is idle, and they stay visible on outputs.

Top module: `pin_xfer_seq`

## Requirements
- R1: After reset these outputs are all zero: `busy_o`, `done_o`, `bus_req_o`, `bc_o`, `de_o`, `hl_o`, `flag_z_o` and `flag_n_o`.
- R2: `ld_en_i` loads BC, DE and HL on the next edge only when the block is idle and `start_i` is low. While the block is busy, a load has no effect.
- R3: Each pass issues an I/O read (`bus_we_o`=0) and then a memory write (`bus_we_o`=1) of the byte returned by that read, to address HL.
  - The read address is {8'h00, BC} in modes 0 and 1, and {8'h00, DE[15:0]} in mode 2.
  - The top byte of the read address is the `IO_FILL` parameter, whose default is zero.
- R4: A request that has not been acknowledged stays asserted, with `bus_addr_o`, `bus_we_o` and `bus_wdata_o` unchanged, until `bus_ack_i` is high.
- R5: Mode 0 decrements B (BC[15:8]) modulo 256 and HL modulo 2^24.
  - C and DE are left unchanged.
  - Z is set exactly when the new B is zero.
- R6: Mode 1 behaves like mode 0 and also decrements C (BC[7:0]) modulo 256.
- R7: Mode 2 decrements BC, DE and HL once per pass.
  - A further pass follows only when BC was greater than 1 at the start of the pass.
  - Z is set exactly when the new BC is zero.
- R8: Mode 2 started with BC=0 makes exactly one transfer, leaves BC at 16'hFFFF and clears Z.
- R9: After each pass, N equals bit 7 of the byte transferred in that pass.
- R10: With zero-wait acknowledges, `busy_o` is high for exactly 2+3·P cycles, where P is the number of passes. `done_o` is high for one cycle, the last busy cycle.
- R11: A start with mode 3 is ignored. A start while the block is busy is ignored: no extra pass and no relaunch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a transfer using `mode_i` |
| mode_i | input | 2 | 0 step, 1 step with C, 2 repeat, 3 reserved |
| ld_en_i | input | 1 | Load the register pairs (idle only) |
| ld_bc_i | input | CNT_W | Value loaded into BC |
| ld_de_i | input | PTR_W | Value loaded into DE |
| ld_hl_i | input | PTR_W | Value loaded into HL |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = memory write, 0 = I/O read |
| bus_addr_o | output | PTR_W | Bus address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, taken with `bus_ack_i` |
| bus_ack_i | input | 1 | Completes the current bus cycle |
| bc_o | output | CNT_W | Current BC |
| de_o | output | PTR_W | Current DE |
| hl_o | output | PTR_W | Current HL |
| flag_z_o | output | 1 | Z flag |
| flag_n_o | output | 1 | N flag |
| busy_o | output | 1 | High from launch through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a long repeat that is stalled at random points by withheld acknowledges while other inputs arrive in the middle of the run. Those inputs are a register load and a second start, and both must leave the transfer stream untouched.

The bench drives the acknowledge from a seeded random enable that changes every cycle. It deliberately pulses the load and start inputs during the third busy cycle, then compares the full logs of read and write addresses against a bench model.

Directed runs cover the boundaries:
- counter wrap in both single-step modes;
- a repeat that starts from zero;
- a one-pass repeat;
- HL wrapping below zero.

// File: rtl/pin_xfer_pkg.sv
package pin_xfer_pkg;

   typedef enum logic [1:0] {
      XM_STEP   = 2'd0,
      XM_STEP_C = 2'd1,
      XM_RPT    = 2'd2,
      XM_RSVD   = 2'd3
   } xfer_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LAUNCH  = 3'd1,
      ST_PORT_RD = 3'd2,
      ST_MEM_WR  = 3'd3,
      ST_UPDATE  = 3'd4,
      ST_FINISH  = 3'd5
   } seq_state_e;

endpackage

// File: rtl/pin_xfer_fsm.sv
module pin_xfer_fsm
   import pin_xfer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       mode_ok,
   input  logic [1:0] mode_in,
   input  logic       bus_ack,
   input  logic       last_pass,
   output seq_state_e state,
   output logic [1:0] mode_q,
   output logic       busy,
   output logic       done,
   output logic       cap_en,
   output logic       upd_en
);

   seq_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (start && mode_ok) state_nx = ST_LAUNCH;
         ST_LAUNCH:  state_nx = ST_PORT_RD;
         ST_PORT_RD: if (bus_ack) state_nx = ST_MEM_WR;
         ST_MEM_WR:  if (bus_ack) state_nx = ST_UPDATE;
         ST_UPDATE:  begin
            if (mode_q == XM_RPT && !last_pass) state_nx = ST_PORT_RD;
            else                                state_nx = ST_FINISH;
         end
         ST_FINISH:  state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= XM_STEP;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start && mode_ok) mode_q <= mode_in;
      end
   end

   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_FINISH);
   assign cap_en = (state == ST_PORT_RD) && bus_ack;
   assign upd_en = (state == ST_UPDATE);

endmodule

// File: rtl/pin_xfer_regs.sv
module pin_xfer_regs
   import pin_xfer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PTR_W  = 24,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [CNT_W-1:0]  ld_bc,
   input  logic [PTR_W-1:0]  ld_de,
   input  logic [PTR_W-1:0]  ld_hl,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] rdata,
   input  logic              upd_en,
   input  logic [1:0]        mode,
   output logic [CNT_W-1:0]  bc,
   output logic [PTR_W-1:0]  de,
   output logic [PTR_W-1:0]  hl,
   output logic [DATA_W-1:0] data_q,
   output logic              flag_z,
   output logic              flag_n,
   output logic              last_pass
);

   localparam int HALF = CNT_W / 2;

   logic [HALF-1:0]  b_dec;
   logic [HALF-1:0]  c_dec;
   logic [CNT_W-1:0] bc_dec;
   logic [PTR_W-1:0] de_dec;
   logic [PTR_W-1:0] hl_dec;

   assign b_dec  = bc[CNT_W-1:HALF] - HALF'(1);
   assign c_dec  = bc[HALF-1:0] - HALF'(1);
   assign bc_dec = bc - CNT_W'(1);
   assign de_dec = de - PTR_W'(1);
   assign hl_dec = hl - PTR_W'(1);

   // the pass in progress is the last when the count was 0 or 1 before it
   assign last_pass = (bc[CNT_W-1:1] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc     <= '0;
         de     <= '0;
         hl     <= '0;
         data_q <= '0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else if (ld_en) begin
         bc <= ld_bc;
         de <= ld_de;
         hl <= ld_hl;
      end else begin
         if (cap_en) data_q <= rdata;
         if (upd_en) begin
            flag_n <= data_q[DATA_W-1];
            hl     <= hl_dec;
            unique case (mode)
               XM_STEP: begin
                  bc[CNT_W-1:HALF] <= b_dec;
                  flag_z           <= (b_dec == '0);
               end
               XM_STEP_C: begin
                  bc     <= {b_dec, c_dec};
                  flag_z <= (b_dec == '0);
               end
               XM_RPT: begin
                  bc     <= bc_dec;
                  de     <= de_dec;
                  flag_z <= (bc_dec == '0);
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pin_xfer_bus.sv
module pin_xfer_bus
   import pin_xfer_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter int               PTR_W   = 24,
   parameter int               DATA_W  = 8,
   parameter logic [PTR_W-1:0] IO_FILL = '0
) (
   input  seq_state_e        state,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  bc,
   input  logic [PTR_W-1:0]  de,
   input  logic [PTR_W-1:0]  hl,
   input  logic [DATA_W-1:0] data_q,
   output logic              req,
   output logic              we,
   output logic [PTR_W-1:0]  addr,
   output logic [DATA_W-1:0] wdata
);

   logic [CNT_W-1:0] port_sel;
   logic [PTR_W-1:0] io_addr;

   assign port_sel = (mode == XM_RPT) ? de[CNT_W-1:0] : bc;

   generate
      if (PTR_W > CNT_W) begin : g_fill
         assign io_addr = {IO_FILL[PTR_W-1:CNT_W], port_sel};
      end else begin : g_nofill
         assign io_addr = port_sel;
      end
   endgenerate

   always_comb begin
      req  = 1'b0;
      we   = 1'b0;
      addr = '0;
      unique case (state)
         ST_PORT_RD: begin
            req  = 1'b1;
            addr = io_addr;
         end
         ST_MEM_WR: begin
            req  = 1'b1;
            we   = 1'b1;
            addr = hl;
         end
         default: ;
      endcase
   end

   assign wdata = data_q;

endmodule

// File: rtl/pin_xfer_seq.sv
module pin_xfer_seq
   import pin_xfer_pkg::*;
#(
   parameter int               CNT_W      = 16,
   parameter int               PTR_W      = 24,
   parameter int               DATA_W     = 8,
   parameter bit               ENABLE_RPT = 1'b1,
   parameter logic [PTR_W-1:0] IO_FILL    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic              ld_en_i,
   input  logic [CNT_W-1:0]  ld_bc_i,
   input  logic [PTR_W-1:0]  ld_de_i,
   input  logic [PTR_W-1:0]  ld_hl_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [PTR_W-1:0]  bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_ack_i,
   output logic [CNT_W-1:0]  bc_o,
   output logic [PTR_W-1:0]  de_o,
   output logic [PTR_W-1:0]  hl_o,
   output logic              flag_z_o,
   output logic              flag_n_o,
   output logic              busy_o,
   output logic              done_o
);

   generate
      if (CNT_W % 2 != 0 || CNT_W < 4) begin : g_bad_cnt
         $error("pin_xfer_seq: CNT_W must be even and at least 4");
      end
      if (PTR_W < CNT_W) begin : g_bad_ptr
         $error("pin_xfer_seq: PTR_W must not be narrower than CNT_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("pin_xfer_seq: DATA_W must be positive");
      end
   endgenerate

   seq_state_e       state;
   logic [1:0]       mode_q;
   logic             mode_ok;
   logic             cap_en;
   logic             upd_en;
   logic             last_pass;
   logic             ld_take;
   logic [DATA_W-1:0] data_q;

   generate
      if (ENABLE_RPT) begin : g_rpt_on
         assign mode_ok = (mode_i != XM_RSVD);
      end else begin : g_rpt_off
         assign mode_ok = (mode_i == XM_STEP) || (mode_i == XM_STEP_C);
      end
   endgenerate

   assign ld_take = ld_en_i && !busy_o && !start_i;

   pin_xfer_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .mode_ok   (mode_ok),
      .mode_in   (mode_i),
      .bus_ack   (bus_ack_i),
      .last_pass (last_pass),
      .state     (state),
      .mode_q    (mode_q),
      .busy      (busy_o),
      .done      (done_o),
      .cap_en    (cap_en),
      .upd_en    (upd_en)
   );

   pin_xfer_regs #(
      .CNT_W  (CNT_W),
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_take),
      .ld_bc     (ld_bc_i),
      .ld_de     (ld_de_i),
      .ld_hl     (ld_hl_i),
      .cap_en    (cap_en),
      .rdata     (bus_rdata_i),
      .upd_en    (upd_en),
      .mode      (mode_q),
      .bc        (bc_o),
      .de        (de_o),
      .hl        (hl_o),
      .data_q    (data_q),
      .flag_z    (flag_z_o),
      .flag_n    (flag_n_o),
      .last_pass (last_pass)
   );

   pin_xfer_bus #(
      .CNT_W   (CNT_W),
      .PTR_W   (PTR_W),
      .DATA_W  (DATA_W),
      .IO_FILL (IO_FILL)
   ) u_bus (
      .state  (state),
      .mode   (mode_q),
      .bc     (bc_o),
      .de     (de_o),
      .hl     (hl_o),
      .data_q (data_q),
      .req    (bus_req_o),
      .we     (bus_we_o),
      .addr   (bus_addr_o),
      .wdata  (bus_wdata_o)
   );

endmodule

// File: rtl/pin_xfer_chk.sv
module pin_xfer_chk #(
   parameter int CNT_W  = 16,
   parameter int PTR_W  = 24,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic [PTR_W-1:0]  bus_addr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_ack_i,
   input logic [PTR_W-1:0]  hl_o,
   input logic              flag_n_o,
   input logic              busy_o,
   input logic              done_o
);

   // R4: a stalled request keeps its address, direction and data
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=>
         (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

   // R10: done lasts a single cycle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: done only inside the busy window, and busy falls right after it
   p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && !bus_req_o) ##1 !busy_o);

   // R11: no bus activity while idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_req_o);

   // R5 (also R6, R7): HL steps down by one two cycles after each write completes
   p_hl_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o && bus_ack_i) |-> ##2 (hl_o == PTR_W'($past(hl_o, 2) - PTR_W'(1))));

   // R9: N follows bit 7 of the written byte
   p_flag_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o && bus_ack_i) |-> ##2 (flag_n_o == $past(bus_wdata_o[DATA_W-1], 2)));

   // R3: a write is always preceded by a completed read
   p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_we_o && bus_ack_i) |=> (bus_req_o && bus_we_o));

endmodule

bind pin_xfer_seq pin_xfer_chk #(
   .CNT_W  (CNT_W),
   .PTR_W  (PTR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_req_o   (bus_req_o),
   .bus_we_o    (bus_we_o),
   .bus_addr_o  (bus_addr_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_ack_i   (bus_ack_i),
   .hl_o        (hl_o),
   .flag_n_o    (flag_n_o),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/pin_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module pin_xfer_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic        ld_en_i = 1'b0;
   logic [15:0] ld_bc_i = '0;
   logic [23:0] ld_de_i = '0;
   logic [23:0] ld_hl_i = '0;
   logic        bus_req_o, bus_we_o;
   logic [23:0] bus_addr_o;
   logic [7:0]  bus_wdata_o, bus_rdata_i;
   logic        bus_ack_i;
   logic [15:0] bc_o;
   logic [23:0] de_o, hl_o;
   logic        flag_z_o, flag_n_o, busy_o, done_o;
   logic        ack_en = 1'b1;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] port_val(input logic [15:0] a);
      logic [7:0] t;
      t = a[7:0] * 8'd29;
      return t ^ a[15:8] ^ 8'h6B;
   endfunction

   assign bus_ack_i   = bus_req_o & ack_en;
   assign bus_rdata_i = port_val(bus_addr_o[15:0]);

   pin_xfer_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .ld_en_i(ld_en_i), .ld_bc_i(ld_bc_i), .ld_de_i(ld_de_i), .ld_hl_i(ld_hl_i),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
      .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   // bus logs
   logic [23:0] rd_log [0:63];
   logic [23:0] wa_log [0:63];
   logic [7:0]  wd_log [0:63];
   int rd_cnt = 0;
   int wr_cnt = 0;

   always @(posedge clk) begin
      if (bus_req_o && bus_ack_i) begin
         if (!bus_we_o) begin
            if (rd_cnt < 64) rd_log[rd_cnt] = bus_addr_o;
            rd_cnt = rd_cnt + 1;
         end else begin
            if (wr_cnt < 64) begin
               wa_log[wr_cnt] = bus_addr_o;
               wd_log[wr_cnt] = bus_wdata_o;
            end
            wr_cnt = wr_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] m, input logic [15:0] bc,
                         input logic [23:0] de, input logic [23:0] hl,
                         input bit zw, input bit poke);
      logic [23:0] exp_ra [0:63];
      logic [23:0] exp_wa [0:63];
      logic [7:0]  exp_wd [0:63];
      logic [15:0] ebc, port;
      logic [23:0] ede, ehl, prev_addr;
      logic        ez, en, stalled, prev_we;
      int nx, cyc, done_cnt, done_at, bad, hold_bad;
      string tag;

      tag = (m == 2'd0) ? "R5" : (m == 2'd1) ? "R6" : "R7";
      // expected model
      nx  = (m == 2'd2) ? ((bc == 16'd0) ? 1 : int'(bc)) : 1;
      ebc = bc; ede = de; ehl = hl; ez = 1'b0; en = 1'b0;
      for (int k = 0; k < nx; k++) begin
         port = (m == 2'd2) ? ede[15:0] : ebc;
         exp_ra[k] = {8'h00, port};
         exp_wa[k] = ehl;
         exp_wd[k] = port_val(port);
         en  = exp_wd[k][7];
         ehl = ehl - 24'd1;
         if (m == 2'd2) begin
            ebc = ebc - 16'd1;
            ede = ede - 24'd1;
            ez  = (ebc == 16'd0);
         end else begin
            ebc[15:8] = ebc[15:8] - 8'd1;
            if (m == 2'd1) ebc[7:0] = ebc[7:0] - 8'd1;
            ez = (ebc[15:8] == 8'd0);
         end
      end

      // load (R2)
      @(negedge clk);
      ld_en_i = 1'b1; ld_bc_i = bc; ld_de_i = de; ld_hl_i = hl;
      @(negedge clk);
      ld_en_i = 1'b0;
      chk(bc_o == bc && de_o == de && hl_o == hl, "R2", "load idle",
          {bc_o, hl_o}, {bc, hl});
      rd_cnt = 0; wr_cnt = 0;
      ack_en = 1'b1;
      start_i = 1'b1; mode_i = m;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 0; done_cnt = 0; done_at = -1; hold_bad = 0; stalled = 0;
      prev_addr = '0; prev_we = 1'b0;
      while (busy_o) begin
         cyc++;
         if (done_o) begin done_cnt++; done_at = cyc; end
         if (stalled && !(bus_req_o && bus_addr_o == prev_addr && bus_we_o == prev_we))
            hold_bad++;
         if (poke && cyc == 3) begin
            ld_en_i = 1'b1; ld_bc_i = ~bc; ld_de_i = ~de; ld_hl_i = ~hl;
            start_i = 1'b1; mode_i = 2'd0;
         end else begin
            ld_en_i = 1'b0; start_i = 1'b0;
         end
         if (!zw) ack_en = ($urandom % 3) != 0;
         stalled   = bus_req_o && !ack_en;
         prev_addr = bus_addr_o;
         prev_we   = bus_we_o;
         @(negedge clk);
      end
      ld_en_i = 1'b0; start_i = 1'b0; ack_en = 1'b1;

      chk(rd_cnt == nx && wr_cnt == nx, "R3", "transfer count", rd_cnt, nx);
      bad = 0;
      for (int k = 0; k < nx && k < 64; k++) begin
         if (rd_log[k] != exp_ra[k] || wa_log[k] != exp_wa[k] || wd_log[k] != exp_wd[k])
            bad++;
      end
      chk(bad == 0, "R3", "read/write address and data stream", bad, 0);
      if (!zw) chk(hold_bad == 0, "R4", "stalled request held", hold_bad, 0);
      chk(bc_o == ebc, tag, "BC", bc_o, ebc);
      chk(de_o == ((m == 2'd2) ? ede : de), tag, "DE", de_o, ede);
      chk(hl_o == ehl, tag, "HL", hl_o, ehl);
      chk(flag_z_o == ez, tag, "Z", flag_z_o, ez);
      chk(flag_n_o == en, "R9", "N", flag_n_o, en);
      chk(done_cnt == 1 && done_at == cyc, "R10", "done pulse last busy cycle", done_at, cyc);
      if (zw) chk(cyc == 2 + 3 * nx, "R10", "busy cycles", cyc, 2 + 3 * nx);
      if (poke) begin
         @(negedge clk);
         chk(!busy_o && rd_cnt == nx, "R11", "start while busy ignored", busy_o, 0);
         chk(bc_o == ebc && hl_o == ehl, "R2", "load while busy ignored", hl_o, ehl);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o && !bus_req_o, "R1", "reset control", {busy_o, done_o, bus_req_o}, 0);
      chk(bc_o == 0 && de_o == 0 && hl_o == 0 && !flag_z_o && !flag_n_o, "R1",
          "reset registers", {bc_o, hl_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_op(2'd0, 16'h0112, 24'h123456, 24'h001000, 1, 0);  // R5 B reaches zero
      run_op(2'd0, 16'h0034, 24'h000000, 24'h000000, 1, 0);  // R5 B and HL wrap
      run_op(2'd1, 16'h0500, 24'h0000AA, 24'h200000, 1, 0);  // R6 C wraps
      run_op(2'd1, 16'h0101, 24'h0000AA, 24'h200010, 0, 0);  // R6 both to zero
      run_op(2'd2, 16'h0001, 24'h00F0F0, 24'h300000, 1, 0);  // R7 single pass
      run_op(2'd2, 16'h0000, 24'h004000, 24'h300100, 1, 0);  // R8 start from zero
      chk(bc_o == 16'hFFFF && !flag_z_o, "R8", "zero-count wrap", bc_o, 16'hFFFF);
      run_op(2'd2, 16'h0005, 24'h0000FE, 24'h000002, 1, 0);  // R7 R10 timing, HL wrap
      run_op(2'd2, 16'h000C, 24'h010080, 24'h400000, 0, 1);  // R2 R4 R11 pokes

      // R11 reserved mode
      rd_cnt = 0; wr_cnt = 0;
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'd3;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy_o && rd_cnt == 0 && wr_cnt == 0, "R11", "mode 3 ignored", rd_cnt, 0);

      // constrained random
      for (int i = 0; i < 30; i++) begin
         logic [1:0]  m;
         logic [15:0] bcv;
         m   = 2'($urandom % 3);
         bcv = (m == 2'd2) ? 16'($urandom % 24) : 16'($urandom);
         run_op(m, bcv, 24'($urandom), 24'($urandom), ($urandom % 2) == 0, (i % 5) == 0);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule